// File: doc/BRIEF.md
# Two-Frame Event Builder

The block takes a continuous stream of frame words from a sensor front end and files every frame into a ring of three frame slots. At any moment one slot is being filled and the other two hold the two most recently completed frames. A trigger pulse asks for an event. The builder waits for the frame in progress to finish, then freezes that frame and the one before it. It writes one event packet into an internal output FIFO: a header word, the older frame, the newer frame, and a trailer word.

A downstream reader drains the FIFO through a valid/ready stream. Frame capture keeps running while an event is being assembled and drained. The input stream is held off only when the next slot to fill is still frozen by the event being assembled. The trigger input and the busy and reject-count outputs are plain level signals with no handshake.

Back-pressure rules: an input word transfers on a clock edge where `in_valid` and `in_ready` are both high. An output word transfers on an edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, `out_data` holds its value.

Top module: `twoframe_evbuild`

## Requirements
- R1: A frame ends on the handshake of a word with `in_last` high. Only the first FRAME_WORDS words of a frame are stored, and later words of that frame are accepted but dropped. `in_ready` is low only while the next slot to fill is frozen by an event in assembly.
- R2: The payload of an event holds the words of the older frozen frame first and then the words of the newer frozen frame. The newer frame is the first frame to complete on a clock edge after the edge that accepted the trigger. The older frame is the one completed just before it, and it is empty if no such frame exists since reset.
- R3: The header is the first word of each event. Bits [31:28] are 0xA, bit 16 is the mode (1 = zero-suppressed), bits [15:0] count the events built since reset (the first event carries 0), and all other bits are 0.
- R4: The trailer is the last word of each event. Bits [31:28] are 0x5, bits [15:0] hold the number of payload words emitted, and all other bits are 0.
- R5: In raw mode (`zs_mode` = 0 on the accepting edge) every stored word is emitted. In zero-suppressed mode (`zs_mode` = 1) words equal to zero are omitted from the payload and from the trailer count.
- R6: A trigger is accepted only when the sequencer is idle and the output FIFO has at least 2*FRAME_WORDS+2 free entries. Any other trigger is rejected and not queued, and it increments the 16-bit `rej_count` on that edge.
- R7: `busy` is high whenever an event is pending or in assembly, or whenever the output FIFO has less room than a worst-case event.
- R8: Event words leave on the output stream in the order they were written. Data is held stable while the stream is stalled, and no word is lost or duplicated.
- R9: Frozen frames are not overwritten. Capture continues into the free slot during assembly and drain.
- R10: After reset, `busy` is 0, `out_valid` is 0, `in_ready` is 1 and `rej_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| zs_mode | input | 1 | Mode for the next accepted trigger: 1 zero-suppressed, 0 raw |
| trig | input | 1 | Trigger request, one sample per cycle |
| busy | output | 1 | A trigger now would be rejected |
| rej_count | output | 16 | Number of rejected triggers, wrapping |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word can be taken |
| in_data | input | DATA_W | Frame word |
| in_last | input | 1 | Word is the last of its frame |
| out_valid | output | 1 | Output word available |
| out_ready | input | 1 | Reader takes the output word |
| out_data | output | DATA_W | Event word |

## Verification
The bench builds the block with its defaults: DATA_W = 32, FRAME_WORDS = 8 and OUT_DEPTH = 32. With 8-word frames, an 11-word frame reaches truncation within a few cycles. A full-size event takes 18 FIFO entries, so one undrained event already leaves too little room, and the room-based rejection can be reached by holding `out_ready` low. Short one-word frames sent right after a trigger push the write side onto the frozen slot while assembly is still running, so the input stall can be seen.

// File: rtl/tfeb_pkg.sv
package tfeb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_FRAME_END,
    ST_WRITE_HEADER,
    ST_COPY_FRAME_A,
    ST_COPY_FRAME_B,
    ST_WRITE_TRAILER,
    ST_DONE
  } seq_state_e;

  localparam logic [3:0] HDR_MARK = 4'hA;
  localparam logic [3:0] TRL_MARK = 4'h5;
  localparam int         SLOTS    = 3;
  localparam int         CNT_W    = 16;

  function automatic logic [1:0] slot_after(input logic [1:0] s);
    return (s == 2'd2) ? 2'd0 : s + 2'd1;
  endfunction

  function automatic logic [1:0] slot_before(input logic [1:0] s);
    return (s == 2'd0) ? 2'd2 : s - 2'd1;
  endfunction

endpackage

// File: rtl/tfeb_fifo.sv
module tfeb_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  output logic              full,
  output logic [CW-1:0]     free,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wp, rp;
  logic [CW-1:0]     cnt;
  logic              push_ok, pop;

  assign full      = (cnt == CW'(DEPTH));
  assign free      = CW'(DEPTH) - cnt;
  assign out_valid = (cnt != '0);
  assign out_data  = mem[rp];
  assign push_ok   = push && !full;
  assign pop       = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_ok) wp <= wp + AW'(1);
      if (pop)     rp <= rp + AW'(1);
      case ({push_ok, pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/tfeb_ring.sv
module tfeb_ring
  import tfeb_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int FRAME_WORDS = 8,
  localparam int AW         = $clog2(FRAME_WORDS),
  localparam int IDX_W      = $clog2(FRAME_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic              frame_done,
  input  logic              arm,
  input  logic              unlock,
  output logic              locked,
  input  logic              rd_sel,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic [IDX_W-1:0]  len_a,
  output logic [IDX_W-1:0]  len_b
);

  localparam logic [IDX_W-1:0] CAP = IDX_W'(FRAME_WORDS);

  logic [DATA_W-1:0] mem [SLOTS][FRAME_WORDS];
  logic [IDX_W-1:0]  flen [SLOTS];
  logic [1:0]        wr_slot, lk_a, lk_b;
  logic [IDX_W-1:0]  wr_ptr;
  logic              hs, has_room;
  logic [1:0]        rd_slot;

  assign in_ready   = !(locked && ((wr_slot == lk_a) || (wr_slot == lk_b)));
  assign hs         = in_valid && in_ready;
  assign frame_done = hs && in_last;
  assign has_room   = (wr_ptr < CAP);
  assign rd_slot    = rd_sel ? lk_b : lk_a;
  assign rd_data    = mem[rd_slot][rd_idx[AW-1:0]];
  assign len_a      = flen[lk_a];
  assign len_b      = flen[lk_b];

  always_ff @(posedge clk) begin
    if (hs && has_room) mem[wr_slot][wr_ptr[AW-1:0]] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_slot <= 2'd0;
      wr_ptr  <= '0;
      for (int s = 0; s < SLOTS; s++) flen[s] <= '0;
    end else if (hs) begin
      if (in_last) begin
        flen[wr_slot] <= has_room ? wr_ptr + IDX_W'(1) : wr_ptr;
        wr_ptr        <= '0;
        wr_slot       <= slot_after(wr_slot);
      end else if (has_room) begin
        wr_ptr <= wr_ptr + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked <= 1'b0;
      lk_a   <= 2'd0;
      lk_b   <= 2'd0;
    end else if (arm && frame_done) begin
      locked <= 1'b1;
      lk_b   <= wr_slot;
      lk_a   <= slot_before(wr_slot);
    end else if (unlock) begin
      locked <= 1'b0;
    end
  end

  // R9
  lock_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !unlock) |=> ($stable(len_a) && $stable(len_b)));

endmodule

// File: rtl/tfeb_seq.sv
module tfeb_seq
  import tfeb_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int FRAME_WORDS = 8,
  parameter int FIFO_CW     = 6,
  localparam int IDX_W      = $clog2(FRAME_WORDS + 1),
  localparam int WORST      = 2 * FRAME_WORDS + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trig,
  input  logic               zs_mode,
  input  logic               frame_done,
  input  logic               locked,
  input  logic [IDX_W-1:0]   len_a,
  input  logic [IDX_W-1:0]   len_b,
  input  logic [DATA_W-1:0]  rd_data,
  input  logic [FIFO_CW-1:0] fifo_free,
  input  logic               fifo_full,
  output logic               arm,
  output logic               unlock,
  output logic               rd_sel,
  output logic [IDX_W-1:0]   rd_idx,
  output logic               push,
  output logic [DATA_W-1:0]  push_data,
  output logic               busy,
  output logic [CNT_W-1:0]   rej_count
);

  seq_state_e       state;
  logic             mode_q;
  logic [CNT_W-1:0] trig_cnt, pay_cnt;
  logic             room_ok, at_end, zero_skip, copying;
  logic [IDX_W-1:0] cur_len;
  logic [DATA_W-1:0] hdr, trl;

  assign room_ok   = (fifo_free >= FIFO_CW'(WORST));
  assign busy      = (state != ST_IDLE) || !room_ok;
  assign arm       = (state == ST_WAIT_FRAME_END);
  assign unlock    = (state == ST_DONE);
  assign rd_sel    = (state == ST_COPY_FRAME_B);
  assign copying   = (state == ST_COPY_FRAME_A) || (state == ST_COPY_FRAME_B);
  assign cur_len   = rd_sel ? len_b : len_a;
  assign at_end    = (rd_idx == cur_len);
  assign zero_skip = mode_q && (rd_data == '0);

  always_comb begin
    hdr = '0;
    hdr[DATA_W-1 -: 4] = HDR_MARK;
    hdr[16]            = mode_q;
    hdr[15:0]          = trig_cnt;
    trl = '0;
    trl[DATA_W-1 -: 4] = TRL_MARK;
    trl[15:0]          = pay_cnt;
  end

  always_comb begin
    push      = 1'b0;
    push_data = rd_data;
    case (state)
      ST_WRITE_HEADER: begin
        push      = !fifo_full;
        push_data = hdr;
      end
      ST_COPY_FRAME_A, ST_COPY_FRAME_B: begin
        push = !at_end && !zero_skip && !fifo_full;
      end
      ST_WRITE_TRAILER: begin
        push      = !fifo_full;
        push_data = trl;
      end
      default: push = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rej_count <= '0;
    end else if (trig && busy) begin
      rej_count <= rej_count + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      mode_q   <= 1'b0;
      trig_cnt <= '0;
      pay_cnt  <= '0;
      rd_idx   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (trig && room_ok) begin
            state  <= ST_WAIT_FRAME_END;
            mode_q <= zs_mode;
          end
        end
        ST_WAIT_FRAME_END: begin
          if (frame_done) state <= ST_WRITE_HEADER;
        end
        ST_WRITE_HEADER: begin
          if (push) begin
            state   <= ST_COPY_FRAME_A;
            rd_idx  <= '0;
            pay_cnt <= '0;
          end
        end
        ST_COPY_FRAME_A, ST_COPY_FRAME_B: begin
          if (at_end) begin
            rd_idx <= '0;
            state  <= (state == ST_COPY_FRAME_A) ? ST_COPY_FRAME_B : ST_WRITE_TRAILER;
          end else if (zero_skip) begin
            rd_idx <= rd_idx + IDX_W'(1);
          end else if (push) begin
            rd_idx  <= rd_idx + IDX_W'(1);
            pay_cnt <= pay_cnt + CNT_W'(1);
          end
        end
        ST_WRITE_TRAILER: begin
          if (push) state <= ST_DONE;
        end
        ST_DONE: begin
          trig_cnt <= trig_cnt + CNT_W'(1);
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6
  room_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && trig && !room_ok) |=> (state == ST_IDLE));

  // R6
  rej_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && busy) |=> (rej_count == $past(rej_count) + CNT_W'(1)));

  // R9
  copy_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    copying |-> locked);

endmodule

// File: rtl/twoframe_evbuild.sv
module twoframe_evbuild
  import tfeb_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int FRAME_WORDS = 8,
  parameter int OUT_DEPTH   = 32,
  localparam int IDX_W      = $clog2(FRAME_WORDS + 1),
  localparam int FIFO_CW    = $clog2(OUT_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              zs_mode,
  input  logic              trig,
  output logic              busy,
  output logic [15:0]       rej_count,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);

  logic               frame_done, arm, unlock, locked, rd_sel;
  logic [IDX_W-1:0]   rd_idx, len_a, len_b;
  logic [DATA_W-1:0]  rd_data, push_data;
  logic               push, fifo_full;
  logic [FIFO_CW-1:0] fifo_free;

  tfeb_ring #(.DATA_W(DATA_W), .FRAME_WORDS(FRAME_WORDS)) ring_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .frame_done(frame_done), .arm(arm), .unlock(unlock), .locked(locked),
    .rd_sel(rd_sel), .rd_idx(rd_idx), .rd_data(rd_data),
    .len_a(len_a), .len_b(len_b)
  );

  tfeb_seq #(.DATA_W(DATA_W), .FRAME_WORDS(FRAME_WORDS), .FIFO_CW(FIFO_CW)) seq_i (
    .clk(clk), .rst_n(rst_n), .trig(trig), .zs_mode(zs_mode),
    .frame_done(frame_done), .locked(locked), .len_a(len_a), .len_b(len_b),
    .rd_data(rd_data), .fifo_free(fifo_free), .fifo_full(fifo_full),
    .arm(arm), .unlock(unlock), .rd_sel(rd_sel), .rd_idx(rd_idx),
    .push(push), .push_data(push_data), .busy(busy), .rej_count(rej_count)
  );

  tfeb_fifo #(.DATA_W(DATA_W), .DEPTH(OUT_DEPTH)) fifo_i (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
    .full(fifo_full), .free(fifo_free),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

endmodule

// File: tb/twoframe_evbuild_tb_top.sv
`timescale 1ns/1ps
module twoframe_evbuild_tb_top;

  localparam int FW = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        zs_mode = 1'b0, trig = 1'b0;
  logic        busy;
  logic [15:0] rej_count;
  logic        in_valid = 1'b0, in_ready, in_last = 1'b0;
  logic [31:0] in_data = '0;
  logic        out_valid, out_ready = 1'b1;
  logic [31:0] out_data;

  always #2 clk = ~clk;

  twoframe_evbuild #(.DATA_W(32), .FRAME_WORDS(FW), .OUT_DEPTH(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .zs_mode(zs_mode), .trig(trig), .busy(busy),
    .rej_count(rej_count), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  logic [31:0] m_last[$], m_cur[$], exp_q[$];
  bit          pending = 0, pmode = 0;
  int          ev_num = 0, rej_m = 0;

  task automatic build_event();
    int pay = 0;
    exp_q.push_back({4'hA, 11'd0, pmode, 16'(ev_num)});
    foreach (m_last[i]) if (!(pmode && m_last[i] == 0)) begin exp_q.push_back(m_last[i]); pay++; end
    foreach (m_cur[i])  if (!(pmode && m_cur[i] == 0))  begin exp_q.push_back(m_cur[i]);  pay++; end
    exp_q.push_back({4'h5, 12'd0, 16'(pay)});
    ev_num++;
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      // R6: reject counter tracks rejected triggers every cycle
      chk(rej_count == 16'(rej_m), "R6 rej_count", 32'(rej_count), 32'(rej_m));
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) chk(0, "R8 unexpected word", out_data, 32'hx);
        else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          // R1 R2 R3 R4 R5 R8: word content and order
          chk(out_data == e, "R2 R3 R4 R5 R8 event word", out_data, e);
        end
      end
      if (in_valid && in_ready) begin
        if (m_cur.size() < FW) m_cur.push_back(in_data);
        if (in_last) begin
          if (pending) begin build_event(); pending = 0; end
          m_last = m_cur;
          m_cur = {};
        end
      end
      if (trig) begin
        if (busy) rej_m++;
        else begin pending = 1; pmode = zs_mode; end
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic put_word(input logic [31:0] d, input bit last);
    bit ok;
    in_valid = 1'b1; in_data = d; in_last = last;
    do begin
      @(negedge clk); ok = in_ready;
      @(posedge clk); #1;
    end while (!ok);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic send_frame(input int n, input logic [31:0] base, input int zero_every);
    for (int i = 0; i < n; i++)
      put_word((zero_every != 0 && i % zero_every == 0) ? 32'd0 : base + 32'(i), i == n - 1);
  endtask

  task automatic pulse_trig(input bit mode);
    zs_mode = mode; trig = 1'b1;
    step(1);
    trig = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    step(5);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk(busy == 0, "R10 busy", 32'(busy), 0);
    chk(out_valid == 0, "R10 out_valid", 32'(out_valid), 0);
    chk(in_ready == 1, "R10 in_ready", 32'(in_ready), 1);
    chk(rej_count == 0, "R10 rej_count", 32'(rej_count), 0);
    step(1);

    // Raw event over two full frames
    send_frame(8, 32'h100, 0);
    send_frame(8, 32'h200, 3);
    pulse_trig(1'b0);
    @(negedge clk);
    chk(busy == 1, "R7 busy after accept", 32'(busy), 1);
    step(1);
    send_frame(5, 32'h300, 0);
    step(40);

    // Zero-suppressed event
    pulse_trig(1'b1);
    send_frame(7, 32'h400, 2);
    step(40);

    // R6: trigger during assembly is rejected
    pulse_trig(1'b0);
    send_frame(1, 32'h500, 0);
    pulse_trig(1'b0);
    step(40);
    chk(rej_count == 1, "R6 reject in assembly", 32'(rej_count), 1);

    // R1: truncation of a long frame
    pulse_trig(1'b0);
    send_frame(11, 32'h600, 0);
    step(40);

    // R9: input stall on frozen slot, capture overlap
    send_frame(8, 32'h700, 0);
    pulse_trig(1'b0);
    send_frame(1, 32'h800, 0);
    send_frame(1, 32'h900, 0);
    in_valid = 1'b1; in_data = 32'hA00; in_last = 1'b0;
    @(negedge clk);
    chk(in_ready == 0, "R9 stall on frozen slot", 32'(in_ready), 0);
    @(posedge clk); #1;
    in_valid = 1'b0;
    send_frame(3, 32'hA00, 0);
    step(40);

    // R6 R7: rejection for lack of output room
    out_ready = 1'b0;
    send_frame(8, 32'hB00, 0);
    pulse_trig(1'b0);
    send_frame(8, 32'hC00, 0);
    step(30);
    @(negedge clk);
    chk(busy == 1, "R7 busy on low room", 32'(busy), 1);
    step(1);
    pulse_trig(1'b0);
    step(2);
    chk(rej_count == 2, "R6 reject on room", 32'(rej_count), 2);
    out_ready = 1'b1;
    step(40);
    @(negedge clk);
    chk(busy == 0, "R7 busy cleared after drain", 32'(busy), 0);
    chk(out_valid == 0, "R8 drained", 32'(out_valid), 0);
    chk(exp_q.size() == 0, "R2 all events emitted", 32'(exp_q.size()), 0);
    chk(ev_num == 6, "R2 event count", 32'(ev_num), 6);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule